// File: doc/BRIEF.md
# Segmented EDID Block Fetch Engine

This engine reads one 128-byte block of a display's capability table over the display data channel. A block number and a one-cycle start pulse are all it needs. From the block number it works out which 256-byte segment to select and whether the block sits in the lower or upper half of that segment. It then walks the block as a series of offset-addressed reads, each of up to one burst length, and moves every received byte into a small receive FIFO. A consumer drains the FIFO through a valid/ready stream.

The bit-level bus controller sits outside this block and is reached through a transaction-level interface. The engine offers one request per burst on a valid/ready handshake. The request carries the device address, the segment-pointer address, the segment, the offset, the length and the read command code. The controller returns data bytes on a second valid/ready stream and finishes each burst with a completion pulse or a NACK pulse. Back-pressure rules are simple. A request stays valid and unchanged until `req_ready` is sampled high. The engine accepts bus bytes only while a burst is outstanding and the FIFO has room. A consumer holding `rx_ready` low keeps the bytes in place and delays the next burst. The engine does not issue another burst until the FIFO is empty.

Status is held on three plain pins. `busy` is high while a block is being fetched. `done` marks a clean finish and `err` marks an abort, and both keep their value until the next start or a soft reset.

Top module: `edid_block_reader`

## Requirements
- R1: A start pulse seen while idle raises `busy` on the next clock, clears `done` and `err`, and empties the receive FIFO. After reset, `busy`, `done`, `err`, `req_valid` and `rx_valid` are all low.
- R2: Every request carries device address 0x50, segment-pointer address 0x60 and command code 4 (explicit-offset read). Its segment field equals the block number shifted right by one bit.
- R3: The first request of a block has offset 0 for an even block number and 128 for an odd one. Each following request has an offset one burst length (16) higher. Every request length is min(bytes left, 16), which gives eight requests per block.
- R4: A request that is not accepted stays valid with segment, offset and length unchanged.
- R5: Bytes accepted from the bus (`phy_data_valid` and `phy_data_ready`) leave on `rx_data` in arrival order and are held while `rx_ready` is low. `phy_data_ready` is high only while a burst is outstanding and the FIFO is not full.
- R6: A new request is raised only after the previous burst has completed and the FIFO has been fully drained.
- R7: When the last burst completes with the correct byte count, `busy` falls and `done` rises on the next clock, and no further request is made.
- R8: A NACK while a burst is outstanding aborts the block on the next clock. `err` rises, `busy` falls, the FIFO is emptied and the remaining bursts are skipped.
- R9: A completion pulse whose burst delivered a byte count other than the requested length aborts the block in the same way as a NACK.
- R10: A burst that is still outstanding after `tmo_limit` cycles is aborted in the same way. A `tmo_limit` of 0 turns the timeout off.
- R11: A start pulse while busy is ignored and the block in progress continues with the same segment and offsets.
- R12: A soft-reset pulse returns the engine to idle on the next clock, clears `done` and `err` and empties the FIFO. It takes precedence over a start pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle request to fetch a block |
| cmd_block | input | 8 | Block number sampled with the start pulse |
| cmd_srst | input | 1 | Soft reset pulse |
| tmo_limit | input | TMO_W | Cycle limit per outstanding burst, 0 = off |
| busy | output | 1 | Block fetch in progress |
| done | output | 1 | Block completed cleanly (held) |
| err | output | 1 | Block aborted (held) |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Bus controller accepts the request |
| req_dev_addr | output | 8 | Capability-table device address |
| req_seg_addr | output | 8 | Segment-pointer device address |
| req_segment | output | 7 | Segment to select |
| req_offset | output | 8 | Byte offset within the segment |
| req_len | output | $clog2(BURST_BYTES+1) | Bytes requested in this burst |
| req_cmd | output | 4 | Read command code |
| phy_data_valid | input | 1 | Byte from the bus valid |
| phy_data_ready | output | 1 | Engine can take a byte |
| phy_data | input | 8 | Byte from the bus |
| phy_done | input | 1 | Burst completion pulse |
| phy_nack | input | 1 | Burst NACK pulse |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |

## Verification
The bench builds the engine with its default parameters: a 128-byte block, a 16-byte burst and a 16-entry FIFO. With these values one fetch takes exactly eight bursts, and every offset from 0 to 240 and from 128 upward is reached across the even and odd blocks the bench requests. Because the FIFO holds exactly one burst, a throttled consumer shows the drain wait between bursts. The 16-bit timeout width lets the bench run one burst that expires at a limit of 20 cycles and another that stays silent for 300 cycles with the timeout turned off.

// File: rtl/edid_rd_pkg.sv
package edid_rd_pkg;
  localparam logic [7:0] TABLE_DEV_ADDR = 8'h50;
  localparam logic [7:0] SEGPTR_ADDR    = 8'h60;
  localparam logic [3:0] CMD_OFFSET_RD  = 4'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DRAIN = 2'd3
  } eng_state_t;
endpackage

// File: rtl/edid_rx_fifo.sv
module edid_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push, pop;

  assign in_ready  = (count != CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign empty     = (count == '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready && !flush;
  assign pop       = out_valid && out_ready && !flush;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R8
  AST_FIFO_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !flush && !in_valid) |=> (count == $past(count) - CNT_W'(1))); // R5
endmodule

// File: rtl/edid_xfer_timer.sv
module edid_xfer_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] count;

  assign expired = run && (limit != '0) && (count == limit - TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (run)   count <= count + TMO_W'(1);
  end

  AST_TMO_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !run); // R10
endmodule

// File: rtl/edid_burst_ctl.sv
module edid_burst_ctl
  import edid_rd_pkg::*;
#(
  parameter int BLOCK_BYTES = 128,
  parameter int BURST_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] block,
  input  logic       srst,
  input  logic       req_ready,
  input  logic       fifo_empty,
  input  logic       byte_push,
  input  logic       phy_done,
  input  logic       phy_nack,
  input  logic       tmo_expired,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       req_valid,
  output logic [6:0] seg,
  output logic [7:0] off,
  output logic [$clog2(BURST_BYTES+1)-1:0] len,
  output logic       flush,
  output logic       wait_phase,
  output logic       tmo_clear
);
  localparam int LEN_W  = $clog2(BURST_BYTES + 1);
  localparam int LEFT_W = $clog2(BLOCK_BYTES + 1);
  localparam logic [7:0] ODD_BASE = 8'(BLOCK_BYTES);

  eng_state_t        st;
  logic [LEFT_W-1:0] left;
  logic [LEN_W-1:0]  rx_cnt, rx_next;
  logic              count_bad, abort;

  generate
    if (BLOCK_BYTES % BURST_BYTES == 0) begin : g_even_split
      assign len = LEN_W'(BURST_BYTES);
    end else begin : g_tail_split
      assign len = (left < LEFT_W'(BURST_BYTES)) ? LEN_W'(left) : LEN_W'(BURST_BYTES);
    end
  endgenerate

  assign rx_next    = rx_cnt + LEN_W'(byte_push);
  assign count_bad  = (rx_next != len);
  assign abort      = (st == ST_WAIT) && (phy_nack || (phy_done && count_bad) || tmo_expired);
  assign busy       = (st != ST_IDLE);
  assign req_valid  = (st == ST_ISSUE);
  assign wait_phase = (st == ST_WAIT);
  assign tmo_clear  = (st == ST_ISSUE);
  assign flush      = srst || ((st == ST_IDLE) && start) || abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      seg    <= '0;
      off    <= '0;
      left   <= '0;
      rx_cnt <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else if (srst) begin
      st   <= ST_IDLE;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            seg  <= block[7:1];
            off  <= block[0] ? ODD_BASE : 8'd0;
            left <= LEFT_W'(BLOCK_BYTES);
            done <= 1'b0;
            err  <= 1'b0;
            st   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_ready) begin
            rx_cnt <= '0;
            st     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (abort) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else if (phy_done) begin
            off  <= off + 8'(len);
            left <= left - LEFT_W'(len);
            if (left == LEFT_W'(len)) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              st <= ST_DRAIN;
            end
          end else begin
            rx_cnt <= rx_next;
          end
        end
        default: begin
          if (fifo_empty) st <= ST_ISSUE;
        end
      endcase
    end
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !srst) |=> busy); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !srst) |=> (req_valid && $stable(off) && $stable(seg) && $stable(len))); // R4
  AST_OFFSET_ON_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (off % 8'(BURST_BYTES) == 8'd0)); // R3
  AST_NACK_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WAIT) && phy_nack && !srst) |=> (!busy && err)); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && start && !srst) |=> $stable(seg)); // R11
  AST_SRST_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !done && !err)); // R12
endmodule

// File: rtl/edid_block_reader.sv
module edid_block_reader
  import edid_rd_pkg::*;
#(
  parameter int BLOCK_BYTES = 128,
  parameter int BURST_BYTES = 16,
  parameter int TMO_W       = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cmd_start,
  input  logic [7:0]                       cmd_block,
  input  logic                             cmd_srst,
  input  logic [TMO_W-1:0]                 tmo_limit,
  output logic                             busy,
  output logic                             done,
  output logic                             err,
  output logic                             req_valid,
  input  logic                             req_ready,
  output logic [7:0]                       req_dev_addr,
  output logic [7:0]                       req_seg_addr,
  output logic [6:0]                       req_segment,
  output logic [7:0]                       req_offset,
  output logic [$clog2(BURST_BYTES+1)-1:0] req_len,
  output logic [3:0]                       req_cmd,
  input  logic                             phy_data_valid,
  output logic                             phy_data_ready,
  input  logic [7:0]                       phy_data,
  input  logic                             phy_done,
  input  logic                             phy_nack,
  output logic                             rx_valid,
  input  logic                             rx_ready,
  output logic [7:0]                       rx_data
);
  logic flush, wait_phase, tmo_clear, tmo_expired;
  logic fifo_in_ready, fifo_empty, byte_push;

  assign req_dev_addr   = TABLE_DEV_ADDR;
  assign req_seg_addr   = SEGPTR_ADDR;
  assign req_cmd        = CMD_OFFSET_RD;
  assign phy_data_ready = wait_phase && fifo_in_ready;
  assign byte_push      = phy_data_valid && phy_data_ready;

  edid_burst_ctl #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .BURST_BYTES(BURST_BYTES)
  ) ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cmd_start),
    .block      (cmd_block),
    .srst       (cmd_srst),
    .req_ready  (req_ready),
    .fifo_empty (fifo_empty),
    .byte_push  (byte_push),
    .phy_done   (phy_done),
    .phy_nack   (phy_nack),
    .tmo_expired(tmo_expired),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .req_valid  (req_valid),
    .seg        (req_segment),
    .off        (req_offset),
    .len        (req_len),
    .flush      (flush),
    .wait_phase (wait_phase),
    .tmo_clear  (tmo_clear)
  );

  edid_rx_fifo #(
    .DEPTH(BURST_BYTES),
    .W    (8)
  ) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_valid (byte_push),
    .in_ready (fifo_in_ready),
    .in_data  (phy_data),
    .out_valid(rx_valid),
    .out_ready(rx_ready),
    .out_data (rx_data),
    .empty    (fifo_empty)
  );

  edid_xfer_timer #(
    .TMO_W(TMO_W)
  ) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (tmo_clear),
    .run    (wait_phase),
    .limit  (tmo_limit),
    .expired(tmo_expired)
  );

  AST_ISSUE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !rx_valid); // R6
  AST_NO_BYTES_OUTSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !phy_data_ready); // R5
endmodule

// File: tb/edid_block_reader_tb_top.sv
module edid_block_reader_tb_top;
  localparam int BURST = 16;
  localparam int BLK   = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0, cmd_srst = 1'b0;
  logic [7:0] cmd_block = '0;
  logic [15:0] tmo_limit = 16'd200;
  logic       busy, done, err, req_valid, req_ready = 1'b0;
  logic [7:0] req_dev_addr, req_seg_addr, req_offset;
  logic [6:0] req_segment;
  logic [4:0] req_len;
  logic [3:0] req_cmd;
  logic       phy_data_valid = 1'b0, phy_data_ready, phy_done = 1'b0, phy_nack = 1'b0;
  logic [7:0] phy_data = '0;
  logic       rx_valid, rx_ready = 1'b1;
  logic [7:0] rx_data;

  always #5 clk = ~clk;

  edid_block_reader dut_i (.*);

  int checks = 0, fails = 0, cyc = 0, pops = 0, thr = 0;
  bit chk_on = 0;

  // behavioural reference state
  int ph = 0, m_seg = 0, m_off = 0, m_left = 0, m_rx = 0, m_tmo = 0;
  bit m_done = 0, m_err = 0;
  byte unsigned q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      finish_sim();
    end
  end

  // reference model, updated from the inputs present before the edge
  always @(posedge clk) begin
    int len, rxn;
    bit pop, push, fl;
    if (!rst_n) begin
      ph = 0; m_done = 0; m_err = 0; m_seg = 0; m_off = 0; m_left = 0;
      q.delete();
    end else begin
      pop  = (q.size() > 0) && rx_ready;
      push = (ph == 2) && (q.size() < BURST) && phy_data_valid;
      fl = 0;
      if (cmd_srst) begin
        ph = 0; m_done = 0; m_err = 0; fl = 1;
      end else begin
        case (ph)
          0: if (cmd_start) begin
               m_seg = cmd_block >> 1; m_off = cmd_block[0] ? 128 : 0;
               m_left = BLK; m_done = 0; m_err = 0; fl = 1; ph = 1;
             end
          1: if (req_ready) begin ph = 2; m_tmo = 0; m_rx = 0; end
          2: begin
               len = (m_left < BURST) ? m_left : BURST;
               rxn = m_rx + int'(push);
               if (phy_nack) begin m_err = 1; ph = 0; fl = 1; end
               else if (phy_done) begin
                 if (rxn != len) begin m_err = 1; ph = 0; fl = 1; end
                 else begin
                   m_off += len; m_left -= len;
                   if (m_left == 0) begin m_done = 1; ph = 0; end
                   else ph = 3;
                 end
               end else if (tmo_limit != 0 && m_tmo == int'(tmo_limit) - 1) begin
                 m_err = 1; ph = 0; fl = 1;
               end else begin
                 m_tmo++; m_rx = rxn;
               end
             end
          default: if (q.size() == 0) ph = 1;
        endcase
      end
      if (fl) q.delete();
      else begin
        if (pop) begin void'(q.pop_front()); pops++; end
        if (push) q.push_back(phy_data);
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    int el;
    if (chk_on && rst_n) begin
      el = (m_left < BURST) ? m_left : BURST;
      chk(busy == (ph != 0), "R1", "busy", busy, ph != 0);
      chk(done == m_done, "R7", "done", done, m_done);
      chk(err == m_err, "R8", "err", err, m_err);
      chk(req_valid == (ph == 1), "R6", "req_valid", req_valid, ph == 1);
      if (ph == 1) begin
        chk(req_segment == m_seg, "R2", "segment", req_segment, m_seg);
        chk(req_offset == (m_off % 256), "R3", "offset", req_offset, m_off % 256);
        chk(req_len == el, "R3", "length", req_len, el);
        chk(req_dev_addr == 8'h50, "R2", "device address", req_dev_addr, 8'h50);
        chk(req_seg_addr == 8'h60, "R2", "segment pointer address", req_seg_addr, 8'h60);
        chk(req_cmd == 4'd4, "R2", "command", req_cmd, 4);
      end
      chk(phy_data_ready == (ph == 2 && q.size() < BURST), "R5", "phy_data_ready",
          phy_data_ready, ph == 2 && q.size() < BURST);
      chk(rx_valid == (q.size() > 0), "R5", "rx_valid", rx_valid, q.size() > 0);
      if (q.size() > 0) chk(rx_data == q[0], "R5", "rx_data", rx_data, q[0]);
    end
  end

  always @(negedge clk) rx_ready = (thr != 0) ? ((cyc % 3) == 0) : 1'b1;

  task automatic pulse_start(input int b);
    cmd_block = 8'(b); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  // mode: 0 normal, 1 nack, 2 short count, 3 silent, 4 slow then normal
  task automatic phy_burst(input int mode, input int stall, input int nack_at, input bit poke);
    int len, o0, s0;
    while (!req_valid) @(negedge clk);
    len = req_len; o0 = req_offset; s0 = req_segment;
    for (int s = 0; s < stall; s++) begin
      if (poke && s == 0) begin cmd_block = 8'd6; cmd_start = 1'b1; end
      @(negedge clk); cmd_start = 1'b0;
      chk(req_valid && req_offset == o0, "R4", "request held", req_offset, o0);
      if (poke && s == 0) chk(req_segment == s0, "R11", "segment after ignored start", req_segment, s0);
    end
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    if (mode == 3) begin
      while (busy) @(negedge clk);
      return;
    end
    if (mode == 4) repeat (300) @(negedge clk);
    for (int i = 0; i < ((mode == 1) ? nack_at : (mode == 2) ? len - 1 : len); i++) begin
      phy_data_valid = 1'b1; phy_data = 8'(o0 + i + s0 * 37);
      @(negedge clk);
    end
    phy_data_valid = 1'b0;
    if (mode == 1) phy_nack = 1'b1; else phy_done = 1'b1;
    @(negedge clk);
    phy_nack = 1'b0; phy_done = 1'b0;
  endtask

  task automatic run_block(input int blk, input int bad_mode, input int bad_at,
                           input int nack_at, input int stall, input bit poke, input int throttle);
    thr = throttle;
    pulse_start(blk);
    for (int b = 0; b < 8; b++) begin
      phy_burst((b == bad_at) ? bad_mode : 0, stall, nack_at, poke && b == 0);
      if (!busy) break;
    end
    while (busy || rx_valid) @(negedge clk);
    thr = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !err, "R1", "reset status", {busy, done, err}, 0);
    chk(!req_valid && !rx_valid, "R1", "reset handshakes", {req_valid, rx_valid}, 0);
    rst_n = 1'b1; chk_on = 1;
    @(negedge clk);

    // even block, free-flowing consumer
    pops = 0;
    run_block(0, 0, 99, 0, 0, 0, 0);
    chk(done && !err, "R7", "block 0 done", done, 1);
    chk(pops == BLK, "R5", "bytes delivered", pops, BLK);

    // odd block, throttled consumer, held requests, ignored start
    pops = 0;
    run_block(3, 0, 99, 0, 3, 1, 1);
    chk(done && !err, "R3", "block 3 done", done, 1);
    chk(pops == BLK, "R6", "bytes delivered with drain", pops, BLK);

    // NACK in the third burst
    run_block(2, 1, 2, 5, 0, 0, 0);
    chk(err && !done, "R8", "nack abort", err, 1);
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); seen += int'(req_valid); end
      chk(seen == 0, "R8", "no request after abort", seen, 0);
    end

    // short burst
    run_block(5, 2, 1, 0, 0, 0, 0);
    chk(err && !done, "R9", "short count abort", err, 1);

    // timeout
    tmo_limit = 16'd20;
    run_block(1, 3, 0, 0, 0, 0, 0);
    chk(err && !done, "R10", "timeout abort", err, 1);

    // timeout disabled, slow device
    tmo_limit = 16'd0;
    run_block(7, 4, 0, 0, 0, 0, 0);
    chk(done && !err, "R10", "no timeout when limit is zero", done, 1);
    tmo_limit = 16'd200;

    // soft reset mid-block
    pulse_start(4);
    phy_burst(0, 0, 0, 0);
    phy_burst(0, 0, 0, 0);
    cmd_srst = 1'b1; @(negedge clk); cmd_srst = 1'b0;
    chk(!busy && !done && !err, "R12", "soft reset idles", {busy, done, err}, 0);
    chk(!rx_valid, "R12", "soft reset flushes", rx_valid, 0);
    cmd_srst = 1'b1; cmd_start = 1'b1; cmd_block = 8'd9;
    @(negedge clk); cmd_srst = 1'b0; cmd_start = 1'b0;
    chk(!busy, "R12", "soft reset beats start", busy, 0);
    repeat (5) @(negedge clk);

    finish_sim();
  end
endmodule